// File: doc/BRIEF.md
# Programmable Sum-of-Products Plane with Term Allocator

This block is the configurable AND-OR core of one logic block. Thirty-six routed signals enter it. Each one is offered to the AND plane in both polarities, which gives 72 columns. Each of 86 product-term rows selects any subset of those columns. A second plane, the allocator, then ORs any chosen set of product terms into each of 16 sum outputs. One term may drive several outputs at once. No output may collect more than 16 terms.

Both planes are held in flops and loaded one bit per cycle through a write port. The port carries a plane select, a row address, a column address and a data bit. Evaluation from `in_vec` to `sum_out` is purely combinational. A write changes the outputs only after the clock edge that captures it. The allocator enforces the per-output limit when a bit is set. A write that would exceed the limit is refused and reported on `cfg_err`.

There is no state machine. Each plane uses one register process for its configuration and one combinational process for its evaluation.

Top module: `pterm_array`

## Requirements
- R1: While reset is asserted and directly after it, every AND-plane and allocator bit is clear, so `sum_out` is all zeros and `cfg_err` is 0.
- R2: A product term with no selected columns evaluates to 1.
- R3: AND-plane column 2*i is input i in true form and column 2*i+1 is input i complemented. A product term is the AND of its selected columns.
- R4: A product term that selects both columns of the same input evaluates to 0 for every input value.
- R5: Each sum output is the OR of the terms assigned to it. An output with no assigned terms is 0.
- R6: A single product term may be assigned to several outputs at once, and each of them follows it.
- R7: Up to 16 terms may be assigned to one output, and each such write is accepted with `cfg_err` low.
- R8: An allocator write of 1 to an unset bit of an output that already holds 16 terms is refused. In the cycle after the capturing edge `cfg_err` is 1. The output's assignment is unchanged.
- R9: `sum_out` follows `in_vec` with no clock. A configuration write does not change `sum_out` before its capturing edge and does take effect right after it.
- R10: Clearing an allocator bit is always accepted, including on a full output. A term may then be added to that output again.
- R11: A write whose row or column lies outside its plane is ignored. Out of range means an AND row of 86 or more, an allocator row of 16 or more, or an allocator column of 86 or more. Such a write does not raise `cfg_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for configuration storage |
| rst_n | input | 1 | Asynchronous active-low reset; clears both planes |
| in_vec | input | 36 | Routed input signals |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | Plane select: 0 = AND plane (row = term, column = literal), 1 = allocator (row = output, column = term) |
| cfg_row | input | 7 | Row address of the bit to write |
| cfg_col | input | 7 | Column address of the bit to write |
| cfg_data | input | 1 | Value written to the addressed bit |
| sum_out | output | 16 | Sum-of-products outputs |
| cfg_err | output | 1 | High for one cycle after a refused allocator write |

## Verification
The assertions assume that `in_vec` and the write port settle between edges. They also assume the write strobe is low throughout reset, because the per-output counters and the stability checks treat every edge without `cfg_we` as one that leaves the configuration unchanged. The bench drives all inputs one time unit after a rising edge and samples the outputs later in the same cycle. It uses in-range and out-of-range addresses alike. It repeatedly fills outputs to their limit, so that refused writes, and the clears that follow them, arise both from directed cases and from the seeded random writes.

// File: rtl/pta_pkg.sv
package pta_pkg;
    typedef enum logic {
        PLANE_AND = 1'b0,
        PLANE_OR  = 1'b1
    } plane_e;

    function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                         input int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction
endpackage

// File: rtl/pta_and_plane.sv
module pta_and_plane #(
    parameter int N_IN   = 36,
    parameter int N_TERM = 86,
    parameter int AW     = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_row,
    input  logic [AW-1:0]     wr_col,
    input  logic              wr_data,
    input  logic [N_IN-1:0]   in_vec,
    output logic [N_TERM-1:0] term_vec
);
    localparam int COLS = 2 * N_IN;
    localparam int TW   = $clog2(N_TERM);
    localparam int CW   = $clog2(COLS);

    logic [N_TERM-1:0][COLS-1:0] plane_q;
    logic [COLS-1:0]             lit_vec;
    logic                        row_ok;
    logic                        col_ok;

    assign row_ok = (wr_row < AW'(N_TERM));
    assign col_ok = (wr_col < AW'(COLS));

    // literal columns: even = true, odd = complement
    for (genvar i = 0; i < N_IN; i++) begin : g_lit
        assign lit_vec[2*i]   = in_vec[i];
        assign lit_vec[2*i+1] = ~in_vec[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            plane_q <= '0;
        end else if (wr_en && row_ok && col_ok) begin
            plane_q[wr_row[TW-1:0]][wr_col[CW-1:0]] <= wr_data;
        end
    end

    always_comb begin
        for (int t = 0; t < N_TERM; t++) begin
            term_vec[t] = ~|(plane_q[t] & ~lit_vec);
        end
    end

    // R11
    and_oob_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !row_ok) |=> $stable(plane_q));
endmodule

// File: rtl/pta_or_plane.sv
module pta_or_plane #(
    parameter int N_TERM  = 86,
    parameter int N_OUT   = 16,
    parameter int MAX_PER = 16,
    parameter int AW      = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_row,
    input  logic [AW-1:0]     wr_col,
    input  logic              wr_data,
    input  logic [N_TERM-1:0] term_vec,
    output logic [N_OUT-1:0]  sum_vec,
    output logic              err_q
);
    localparam int TW   = $clog2(N_TERM);
    localparam int OW   = $clog2(N_OUT);
    localparam int CNTW = $clog2(MAX_PER + 1);

    logic [N_OUT-1:0][N_TERM-1:0] grid_q;
    logic [N_OUT-1:0][CNTW-1:0]   cnt_q;
    logic                         addr_ok;
    logic                         cur_bit;
    logic                         full;
    logic                         reject;
    logic                         accept;
    logic [OW-1:0]                r_idx;
    logic [TW-1:0]                c_idx;

    assign r_idx   = wr_row[OW-1:0];
    assign c_idx   = wr_col[TW-1:0];
    assign addr_ok = (wr_row < AW'(N_OUT)) && (wr_col < AW'(N_TERM));

    always_comb begin
        cur_bit = grid_q[r_idx][c_idx];
        full    = (cnt_q[r_idx] == CNTW'(MAX_PER));
        reject  = wr_en && addr_ok && wr_data && !cur_bit && full;
        accept  = wr_en && addr_ok && !reject;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            grid_q <= '0;
            cnt_q  <= '0;
            err_q  <= 1'b0;
        end else begin
            err_q <= reject;
            if (accept && (wr_data != cur_bit)) begin
                grid_q[r_idx][c_idx] <= wr_data;
                cnt_q[r_idx]         <= wr_data ? cnt_q[r_idx] + 1'b1
                                                : cnt_q[r_idx] - 1'b1;
            end
        end
    end

    always_comb begin
        for (int o = 0; o < N_OUT; o++) begin
            sum_vec[o] = |(grid_q[o] & term_vec);
        end
    end

    for (genvar o = 0; o < N_OUT; o++) begin : g_chk
        // R7
        cnt_le_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
            cnt_q[o] <= CNTW'(MAX_PER));
        // R8
        cnt_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
            int'(cnt_q[o]) == $countones(grid_q[o]));
    end

    // R8
    reject_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reject |=> $stable(grid_q));
endmodule

// File: rtl/pterm_array.sv
module pterm_array
    import pta_pkg::*;
#(
    parameter int N_IN    = 36,
    parameter int N_TERM  = 86,
    parameter int N_OUT   = 16,
    parameter int MAX_PER = 16,
    localparam int AW     = int'(max3($clog2(N_TERM), $clog2(2 * N_IN), $clog2(N_OUT)))
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_IN-1:0]  in_vec,
    input  logic             cfg_we,
    input  logic             cfg_sel,
    input  logic [AW-1:0]    cfg_row,
    input  logic [AW-1:0]    cfg_col,
    input  logic             cfg_data,
    output logic [N_OUT-1:0] sum_out,
    output logic             cfg_err
);
    plane_e            psel;
    logic              and_we;
    logic              or_we;
    logic [N_TERM-1:0] term_vec;

    assign psel   = plane_e'(cfg_sel);
    assign and_we = cfg_we && (psel == PLANE_AND);
    assign or_we  = cfg_we && (psel == PLANE_OR);

    pta_and_plane #(.N_IN(N_IN), .N_TERM(N_TERM), .AW(AW)) u_and (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (and_we),
        .wr_row   (cfg_row),
        .wr_col   (cfg_col),
        .wr_data  (cfg_data),
        .in_vec   (in_vec),
        .term_vec (term_vec)
    );

    pta_or_plane #(.N_TERM(N_TERM), .N_OUT(N_OUT), .MAX_PER(MAX_PER), .AW(AW)) u_or (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (or_we),
        .wr_row   (cfg_row),
        .wr_col   (cfg_col),
        .wr_data  (cfg_data),
        .term_vec (term_vec),
        .sum_vec  (sum_out),
        .err_q    (cfg_err)
    );

    // R9
    hold_without_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> ($stable(in_vec) -> $stable(sum_out)));
    // R8
    err_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> !cfg_err);
endmodule

// File: tb/sim_pterm_array.sv
`timescale 1ns/1ps
module sim_pterm_array;
    logic        clk = 0;
    logic        rst_n;
    logic [35:0] in_vec;
    logic        cfg_we;
    logic        cfg_sel;
    logic [6:0]  cfg_row;
    logic [6:0]  cfg_col;
    logic        cfg_data;
    logic [15:0] sum_out;
    logic        cfg_err;

    int checks = 0;
    int errors = 0;

    bit [71:0] m_and [86];
    bit [85:0] m_or  [16];
    int        m_cnt [16];

    pterm_array u0 (.*);

    always #5 clk = ~clk;

    function automatic bit exp_term(int t, logic [35:0] v);
        for (int c = 0; c < 72; c++) begin
            if (m_and[t][c]) begin
                if (c % 2 == 0 && v[c/2] !== 1'b1) return 0;
                if (c % 2 == 1 && v[c/2] !== 1'b0) return 0;
            end
        end
        return 1;
    endfunction

    function automatic logic [15:0] exp_sums(logic [35:0] v);
        logic [15:0] s = '0;
        for (int o = 0; o < 16; o++)
            for (int t = 0; t < 86; t++)
                if (m_or[o][t] && exp_term(t, v)) s[o] = 1'b1;
        return s;
    endfunction

    task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic chk_sums(string tag);
        logic [15:0] e = exp_sums(in_vec);
        chk(sum_out === e, tag, 32'(sum_out), 32'(e));
    endtask

    task automatic set_in(logic [35:0] v, string tag);
        in_vec = v;
        #1;
        chk_sums(tag);
    endtask

    task automatic wr(bit pl, int row, int col, bit d, string tag);
        bit rej = 0;
        cfg_we = 1; cfg_sel = pl; cfg_row = 7'(row); cfg_col = 7'(col); cfg_data = d;
        #1;
        chk_sums({tag, " R9 pre-edge"});
        if (!pl) begin
            if (row < 86 && col < 72) m_and[row][col] = d;
        end else if (row < 16 && col < 86) begin
            if (d && !m_or[row][col] && m_cnt[row] == 16) rej = 1;
            else if (d != m_or[row][col]) begin
                m_or[row][col] = d;
                m_cnt[row] += d ? 1 : -1;
            end
        end
        @(posedge clk); #1;
        cfg_we = 0;
        #1;
        chk(cfg_err === rej, {tag, " err"}, 32'(cfg_err), 32'(rej));
        chk_sums({tag, " R9 post-edge"});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        foreach (m_and[t]) m_and[t] = '0;
        foreach (m_or[o]) begin m_or[o] = '0; m_cnt[o] = 0; end
        rst_n = 0; cfg_we = 0; cfg_sel = 0; cfg_row = 0; cfg_col = 0; cfg_data = 0;
        in_vec = 36'hF_FFFF_FFFF;
        repeat (3) @(posedge clk);
        #1;
        chk(sum_out === 16'h0, "R1 sums in reset", 32'(sum_out), 0);
        chk(cfg_err === 1'b0, "R1 err in reset", 32'(cfg_err), 0);
        rst_n = 1;
        @(posedge clk); #1;
        chk(sum_out === 16'h0, "R1 sums after reset", 32'(sum_out), 0);

        // R5: nothing assigned
        for (int k = 0; k < 4; k++) set_in(36'({$urandom, $urandom}), "R5 empty outputs");

        // R2: empty term 0 on output 0
        wr(1, 0, 0, 1, "R2 assign");
        chk(sum_out[0] === 1'b1, "R2 empty term is 1", 32'(sum_out[0]), 1);

        // R3: term 1 = in3 & ~in5, on output 1
        wr(0, 1, 6, 1, "R3 col");
        wr(0, 1, 11, 1, "R3 col");
        wr(1, 1, 1, 1, "R3 assign");
        set_in(36'h8, "R3 in3=1 in5=0");
        chk(sum_out[1] === 1'b1, "R3 true", 32'(sum_out[1]), 1);
        set_in(36'h28, "R3 in3=1 in5=1");
        chk(sum_out[1] === 1'b0, "R3 false", 32'(sum_out[1]), 0);
        set_in(36'h0, "R3 in3=0");
        chk(sum_out[1] === 1'b0, "R3 false", 32'(sum_out[1]), 0);

        // R4: term 2 selects in4 and ~in4
        wr(0, 2, 8, 1, "R4 col");
        wr(0, 2, 9, 1, "R4 col");
        wr(1, 2, 2, 1, "R4 assign");
        set_in(36'h10, "R4 in4=1");
        chk(sum_out[2] === 1'b0, "R4 contradictory", 32'(sum_out[2]), 0);
        set_in(36'h0, "R4 in4=0");
        chk(sum_out[2] === 1'b0, "R4 contradictory", 32'(sum_out[2]), 0);

        // R6: share term 1 on output 3
        wr(1, 3, 1, 1, "R6 share");
        for (int k = 0; k < 6; k++) begin
            set_in(36'({$urandom, $urandom}), "R6 shared");
            chk(sum_out[3] === sum_out[1], "R6 outputs agree", 32'(sum_out[3]), 32'(sum_out[1]));
        end

        // R7/R8/R10: output 5 filled to 16 terms
        for (int t = 10; t < 25; t++) wr(0, t, 0, 1, "R7 term needs in0");
        wr(0, 25, 2, 1, "R7 term needs in1");
        for (int t = 10; t < 26; t++) wr(1, 5, t, 1, "R7 fill");
        set_in(36'h2, "R7 in1");
        chk(sum_out[5] === 1'b1, "R7 16th term live", 32'(sum_out[5]), 1);
        set_in(36'h0, "R8 quiet");
        wr(1, 5, 26, 1, "R8 17th term");
        chk(sum_out[5] === 1'b0, "R8 assignment kept", 32'(sum_out[5]), 0);
        @(posedge clk); #1;
        chk(cfg_err === 1'b0, "R8 err one cycle", 32'(cfg_err), 0);
        wr(1, 5, 10, 0, "R10 clear on full");
        wr(1, 5, 26, 1, "R10 re-add");
        chk(sum_out[5] === 1'b1, "R10 new term live", 32'(sum_out[5]), 1);

        // R11: out-of-range addresses
        wr(0, 100, 0, 1, "R11 and row");
        wr(1, 20, 0, 1, "R11 or row");
        wr(1, 0, 90, 1, "R11 or col");
        wr(1, 3, 0, 1, "R11 in-range control");

        // random mix
        for (int k = 0; k < 600; k++) begin
            if ($urandom_range(0, 1) == 0)
                wr(0, $urandom_range(0, 90), $urandom_range(0, 75),
                   $urandom_range(0, 9) < 2, "rand R3 and-plane");
            else
                wr(1, $urandom_range(0, 17), $urandom_range(0, 88),
                   $urandom_range(0, 9) < 7, "rand R8 allocator");
            set_in(36'({$urandom, $urandom}), "rand R5 sums");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule